// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block owns the write path of the status register inside a serial memory device. A serial front end, which lies outside this block, decodes the instruction stream. It hands this block a strobe for the write-enable command, a strobe for the write-status command, each received data byte, and a flag that tells whether the transfer ended on a byte boundary. The block keeps the write-enable latch and the nonvolatile status fields. These are a protection-enable bit and a two-bit block-protect field. The block also decides whether a status write may go ahead.

A status write is committed only when the select line rises at the end of a well-formed sequence. The block weighs the write-protect pin against the protection-enable bit. The pin counts only when that bit is set. If the write is allowed, a timed internal write cycle starts. During the cycle the device reports busy. New commands are ignored and neither the pin nor the select line can cut the cycle short. When the cycle ends, the new field values land in the register and the write-enable latch clears.

All inputs are synchronous to `clk`. The select and protect pins are assumed to be synchronised already.

Top module: `srwp_ctrl`

## Requirements
- R1: After reset `status` reads 8'h00 and `busy` is 0. Status layout: bit 7 protection-enable, bits 3:2 block-protect, bit 1 write-enable latch, bit 0 busy, bits 6:4 always 0.
- R2: A `wren_cmd` pulse sampled while `cs_n` is low and the block is idle sets status bit 1.
- R3: A write-status sequence starts a write cycle on the cycle in which `cs_n` is first seen high again, if all of these hold: the sequence delivered at least one data byte, bit 1 is set, `byte_whole` is 1 in that cycle, and the sequence is not protected. `busy` is then 1 from the next cycle for exactly WR_CYCLES cycles. When it drops, bits 7 and 3:2 take bits 7 and 3:2 of the first data byte and bit 1 clears.
- R4: A sequence is protected when status bit 7 is 1 and `wp_n` was low in any sampled cycle from the command up to and including the `cs_n` rise cycle. A protected sequence starts no cycle and leaves `status` unchanged.
- R5: While status bit 7 is 0, `wp_n` has no effect; a sequence with `wp_n` held low writes normally.
- R6: If the write-enable latch is clear, no data byte arrived, or `byte_whole` is 0 at the rise, the `cs_n` rise is ignored and `status` is unchanged.
- R7: Once a cycle has started, `wp_n` and `cs_n` activity changes neither its length nor the value it commits.
- R8: While `busy` is 1, `wren_cmd`, `wrsr_cmd` and data bytes are ignored. No second cycle follows, and bit 1 reads 0 after the cycle ends.
- R9: Command strobes sampled while `cs_n` is high are ignored. A `cs_n` level that has stayed high since reset is not a sequence end.
- R10: Only the first data byte of a sequence is used; later bytes are ignored. Bits 6:4 and 1:0 of the byte are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low; its rise ends a sequence |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_cmd | input | 1 | Decoded write-enable command strobe |
| wrsr_cmd | input | 1 | Decoded write-status command strobe |
| byte_valid | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | 8 | Received data byte |
| byte_whole | input | 1 | The transfer holds a whole number of bytes |
| status | output | 8 | Status register contents |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two events can land in the same cycle. The first is the protect pin going low in the very cycle the select line rises. The bench drives `wp_n` low together with the `cs_n` rise and expects no cycle when protection is enabled, but a normal write when it is not. The second is a full new sequence run while a write cycle is in progress. That sequence includes a write-enable strobe, its own select rise and a pin drop. The bench then expects the original cycle length and value, and a cleared latch at its end. Random sequences mix data, pin timing, byte alignment and latch state around these directed cases. Each random result is compared with a bench model of the register.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_PEN  = 7;
    localparam int BIT_BPH  = 3;
    localparam int BIT_BPL  = 2;
    localparam int BIT_WEL  = 1;
    localparam int BIT_BUSY = 0;

    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
    } nv_fields_t;

    typedef struct packed {
        logic       active;
        logic       have_data;
        logic       pin_low;
        nv_fields_t pend;
    } seq_state_t;

    typedef enum logic {
        WC_IDLE = 1'b0,
        WC_RUN  = 1'b1
    } wc_state_e;

    function automatic nv_fields_t nv_from_byte(input logic [BYTE_W-1:0] b);
        nv_fields_t f;
        f.pen = b[BIT_PEN];
        f.bp  = b[BIT_BPH:BIT_BPL];
        return f;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input nv_fields_t f,
                                                      input logic wel,
                                                      input logic bsy);
        logic [BYTE_W-1:0] s;
        s                   = '0;
        s[BIT_PEN]          = f.pen;
        s[BIT_BPH:BIT_BPL]  = f.bp;
        s[BIT_WEL]          = wel;
        s[BIT_BUSY]         = bsy;
        return s;
    endfunction

endpackage

// File: rtl/srwp_seq_track.sv
module srwp_seq_track
    import srwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wrsr_cmd,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              busy,
    output logic              cs_rise,
    output logic              pin_low_seen,
    output seq_state_t        seq
);

    logic cs_q;
    logic sel;

    assign sel          = ~cs_n;
    assign cs_rise      = ~cs_q & cs_n;
    assign pin_low_seen = seq.pin_low | ~wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
            seq  <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_rise) begin
                seq <= '0;
            end else if (sel && !busy) begin
                if (wrsr_cmd && !seq.active) begin
                    seq.active    <= 1'b1;
                    seq.have_data <= 1'b0;
                    seq.pin_low   <= ~wp_n;
                end else if (seq.active) begin
                    seq.pin_low <= seq.pin_low | ~wp_n;
                    if (byte_valid && !seq.have_data) begin
                        seq.have_data <= 1'b1;
                        seq.pend      <= nv_from_byte(byte_data);
                    end
                end
            end
        end
    end

    // R9: a sequence cannot survive two cycles of deselect
    p_no_seq_when_deselected_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !seq.active);

    // R10: the captured byte is held once data has arrived
    p_first_byte_held_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(seq.have_data) && seq.have_data) |-> $stable(seq.pend));

endmodule

// File: rtl/srwp_wr_timer.sv
module srwp_wr_timer
    import srwp_pkg::*;
#(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    wc_state_e      st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= WC_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                WC_IDLE: begin
                    if (start) begin
                        st  <= WC_RUN;
                        cnt <= CW'(CYCLES - 1);
                    end
                end
                WC_RUN: begin
                    if (cnt == '0) begin
                        st <= WC_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= WC_IDLE;
            endcase
        end
    end

    assign busy = (st == WC_RUN);
    assign done = (st == WC_RUN) && (cnt == '0);

    // R3: counter never exceeds the programmed length while running
    p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(CYCLES)));

    // R3: a cycle ends only after the count has run out
    p_end_after_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(cnt) == '0));

endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
#(
    parameter int WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wren_cmd,
    input  logic              wrsr_cmd,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_whole,
    output logic [BYTE_W-1:0] status,
    output logic              busy
);

    seq_state_t seq;
    nv_fields_t nv_q;
    nv_fields_t nv_next;
    logic       wel_q;
    logic       cs_rise;
    logic       pin_low_seen;
    logic       guarded;
    logic       start;
    logic       done;

    srwp_seq_track u_seq (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .wp_n         (wp_n),
        .wrsr_cmd     (wrsr_cmd),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .busy         (busy),
        .cs_rise      (cs_rise),
        .pin_low_seen (pin_low_seen),
        .seq          (seq)
    );

    srwp_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // Pin only matters when the protection-enable bit is set
    assign guarded = nv_q.pen & pin_low_seen;

    always_comb begin
        start = cs_rise && seq.active && seq.have_data && wel_q
                && byte_whole && !busy && !guarded;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q   <= 1'b0;
            nv_q    <= '0;
            nv_next <= '0;
        end else begin
            if (start) begin
                nv_next <= seq.pend;
            end
            if (done) begin
                nv_q  <= nv_next;
                wel_q <= 1'b0;
            end else if (wren_cmd && !cs_n && !busy) begin
                wel_q <= 1'b1;
            end
        end
    end

    assign status = pack_status(nv_q, wel_q, busy);

    // R6: a cycle begins only with the latch set
    p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(status[BIT_WEL]));

    // R4: a cycle never begins with protection active and the pin low at the rise
    p_protect_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !($past(status[BIT_PEN]) && !$past(wp_n)));

    // R9: a cycle begins only on a cycle where the select line is high
    p_start_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_n));

    // R7: nonvolatile fields move only as a cycle ends
    p_nv_only_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> ($stable(status[BIT_PEN]) && $stable(status[BIT_BPH:BIT_BPL])));

    // R3: latch is clear once a cycle has ended
    p_wel_clear_at_end_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !status[BIT_WEL]);

endmodule

// File: tb/srwp_ctrl_tb.sv
module srwp_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WR         = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, wp_n, wren_cmd, wrsr_cmd, byte_valid, byte_whole;
    logic [7:0] byte_data;
    logic [7:0] status;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic       e_pen;
    logic [1:0] e_bp;
    logic       e_wel;

    always #(CLK_PERIOD/2) clk = ~clk;

    srwp_ctrl #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .wren_cmd(wren_cmd), .wrsr_cmd(wrsr_cmd),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_whole(byte_whole), .status(status), .busy(busy)
    );

    function automatic logic [7:0] exp_st(input logic pen, input logic [1:0] bp,
                                          input logic wel, input logic bsy);
        return {pen, 3'b000, bp, wel, bsy};
    endfunction

    function automatic logic allowed(input logic pen, input logic pin_low);
        return !(pen && pin_low);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_wel();
        step(); cs_n = 1'b0;
        step(); wren_cmd = 1'b1;
        step(); wren_cmd = 1'b0;
        step(); cs_n = 1'b1;
        step();
        if (!busy) e_wel = 1'b1;
    endtask

    // disturb: run a full competing sequence while the cycle is in progress
    task automatic finish_cycle(input string req, input logic [7:0] d, input bit disturb);
        for (int i = 1; i < WR; i++) begin
            step();
            if (disturb) begin
                case (i)
                    1: cs_n = 1'b0;
                    2: begin wren_cmd = 1'b1; wp_n = 1'b0; end
                    3: begin wren_cmd = 1'b0; wrsr_cmd = 1'b1; end
                    4: begin wrsr_cmd = 1'b0; byte_valid = 1'b1; byte_data = ~d; end
                    5: begin byte_valid = 1'b0; cs_n = 1'b1; wp_n = 1'b1; end
                    default: ;
                endcase
            end
            chk({req, " busy held"}, status, exp_st(e_pen, e_bp, 1'b1, 1'b1));
        end
        step();
        e_pen = d[7];
        e_bp  = d[3:2];
        e_wel = 1'b0;
        chk({req, " commit"}, {status[7:1], busy}, exp_st(e_pen, e_bp, 1'b0, 1'b0));
    endtask

    // wp_mode: 0 pin high, 1 pin low whole sequence, 2 pin low only in the rise cycle
    task automatic run_seq(input string req, input logic [7:0] d, input bit cmd,
                           input bit byt, input bit whole, input int wp_mode,
                           input bit disturb);
        bit go;
        go = cmd && byt && whole && e_wel && allowed(e_pen, wp_mode != 0);
        step(); cs_n = 1'b0; wp_n = (wp_mode == 1) ? 1'b0 : 1'b1;
        step(); wrsr_cmd = cmd;
        step(); wrsr_cmd = 1'b0; byte_valid = byt; byte_data = d;
        step(); byte_valid = byt; byte_data = ~d;
        step(); byte_valid = 1'b0; cs_n = 1'b1; byte_whole = whole;
                if (wp_mode == 2) wp_n = 1'b0;
        step(); wp_n = 1'b1; byte_whole = 1'b1;
        chk({req, " start"}, {7'd0, busy}, {7'd0, go});
        if (go) begin
            finish_cycle(req, d, disturb);
        end else begin
            step();
            chk({req, " unchanged"}, status, exp_st(e_pen, e_bp, e_wel, 1'b0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit cmd, byt, whole;
        int wpm;
        void'($urandom(32'd1357));
        rst = 1'b1; cs_n = 1'b1; wp_n = 1'b1; wren_cmd = 1'b0; wrsr_cmd = 1'b0;
        byte_valid = 1'b0; byte_data = 8'h00; byte_whole = 1'b1;
        e_pen = 1'b0; e_bp = 2'b00; e_wel = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 reset", {status[7:1], busy}, 8'h00);

        // R9: strobes while deselected are ignored
        wren_cmd = 1'b1; wrsr_cmd = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
        step(); wren_cmd = 1'b0; wrsr_cmd = 1'b0; byte_valid = 1'b0;
        step(); step();
        chk("R9 deselected strobes", {status[7:1], busy}, 8'h00);

        // R6: no latch
        run_seq("R6 latch clear", 8'h8C, 1, 1, 1, 0, 0);
        // R2
        set_wel();
        chk("R2 latch set", status, exp_st(e_pen, e_bp, 1'b1, 1'b0));
        // R6: partial byte, no data
        run_seq("R6 partial byte", 8'h8C, 1, 1, 0, 0, 0);
        run_seq("R6 no data", 8'h8C, 1, 0, 1, 0, 0);
        // R5: protection off, pin held low
        run_seq("R5 pin ignored", 8'h08, 1, 1, 1, 1, 0);
        // R3 + R10: bits 7,3,2 from first byte, others discarded
        set_wel();
        run_seq("R3 R10 write", 8'hF3 & 8'hBF | 8'h80, 1, 1, 1, 0, 0);
        // R4: pin low only in the rise cycle
        set_wel();
        run_seq("R4 pin at rise", 8'h00, 1, 1, 1, 2, 0);
        run_seq("R4 pin whole seq", 8'h00, 1, 1, 1, 1, 0);
        // R7 + R8: disturbance during cycle
        run_seq("R7 R8 disturbed", 8'h84, 1, 1, 1, 0, 1);
        chk("R8 latch after cycle", status, exp_st(e_pen, e_bp, 1'b0, 1'b0));

        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(0, 3) != 0) set_wel();
            d     = 8'($urandom);
            cmd   = ($urandom_range(0, 7) != 0);
            byt   = ($urandom_range(0, 7) != 0);
            whole = ($urandom_range(0, 5) != 0);
            wpm   = $urandom_range(0, 2);
            run_seq("R3 R4 R5 R6 random", d, cmd, byt, whole, wpm,
                    ($urandom_range(0, 3) == 0));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule